// File: doc/BRIEF.md
# 1-Wire Bus Master Controller

This block is a register-mapped master for a single open-drain 1-Wire line. Software talks to it through a small four-register read/write port. Writing a start bit in the control register runs a bus reset and records whether any slave answered with a presence pulse. Writing the data register sends a byte as eight time slots, least significant bit first. The byte sampled back from the line during those slots is then readable from the same register. A transmitted 1 bit gives a read slot, so writing 0xFF reads a full byte from a slave.

All slot and reset timing counts microseconds. A prescaler produces a one-microsecond tick from the system clock. The prescaler restarts at each operation, so every operation has exact, repeatable timing.

Three sticky flags report events: a completed receive, a line found shorted low at the end of an operation, and a low line seen while the bus was idle. Each flag is cleared by writing 1 to it. Each flag can raise the interrupt output through its own enable bit. A bit-bang mode lets software drive the line level directly.

Register map (2-bit address): 0 = control, 1 = data, 2 = flags, 3 = interrupt enable.

Top module: `onewire_master`

## Requirements
- R1: Writing control bit 0 = 1 while idle starts a reset. The line is held low for 480 µs, each µs being CLK_PER_US clock cycles, and is then released. Control bit 0 and control bit 4 (busy) read 1 until the sequence ends 960 µs after it started, and 0 after that.
- R2: Control bit 3 (presence) reads 1 after a reset if the line was low 70 µs after release, and 0 if it was high then.
- R3: A write to the data register (address 1) while idle sends the byte least significant bit first, in 65 µs slots. A 1 bit is a 6 µs low pulse and a 0 bit is a 60 µs low pulse.
- R4: After a complete byte, reading the data register returns the eight line levels sampled 15 µs into each slot, with the first slot in bit 0.
- R5: Flag bit 0 (receive ready, address 2) sets when a byte completes.
- R6: If the line is low at the end of a slot or at the end of a reset, flag bit 1 (short) sets, the operation stops at once, busy clears, and receive ready does not set.
- R7: Flag bit 2 (line low) sets when the bus is idle and has been released for at least three clock cycles, and the sampled line is low.
- R8: Writes to the data register or to control bit 0 while busy are ignored. No new reset is issued and the byte in progress is unchanged.
- R9: Control bit 1 enables bit-bang mode. In this mode control bit 2 = 1 drives the line low and 0 releases it. The line-low flag is not raised by the block's own bit-bang drive.
- R10: The interrupt output is 1 in the cycle after any flag bit is set together with its matching enable bit in address 3 (bits 2:0), and 0 otherwise.
- R11: Writing 1 to a flag bit clears only that bit; bits written 0 are left unchanged.
- R12: After reset, the line is released, the interrupt is low, and the control and flag registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, valid the cycle after the address |
| ow_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| ow_in | input | 1 | Line level as seen at the pin |
| irq | output | 1 | Interrupt request, registered |

## Verification
The assertions assume that register writes never reach the engine's start inputs while it is busy. They also assume that the line, apart from a short, is released by every slave within the slot time, so an idle engine and a set bit-bang level alone decide the output. The bench slave model keeps its reply pulses (20–120 µs presence, 30 µs zero reply) well inside these windows. A short is forced only through a separate bench control, and the model's bit index is realigned by a reset before any later byte depends on it.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;
  localparam int NFLAG  = 3;

  localparam logic [REG_AW-1:0] A_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] A_DATA  = 2'd1;
  localparam logic [REG_AW-1:0] A_FLAGS = 2'd2;
  localparam logic [REG_AW-1:0] A_IEN   = 2'd3;

  localparam int F_RXRDY = 0;
  localparam int F_SHORT = 1;
  localparam int F_LOW   = 2;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RST  = 2'd1,
    ENG_SLOT = 2'd2
  } eng_state_t;
endpackage

// File: rtl/ow_tick.sv
module ow_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ow_engine.sv
module ow_engine
  import ow_pkg::*;
#(
  parameter int DW           = 8,
  parameter int T_RST_LOW    = 480,
  parameter int T_PRES       = 70,
  parameter int T_RST_TOTAL  = 960,
  parameter int T_SLOT       = 65,
  parameter int T_LOW1       = 6,
  parameter int T_LOW0       = 60,
  parameter int T_SAMPLE     = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rst_go,
  input  logic          byte_go,
  input  logic [DW-1:0] tx_byte,
  input  logic          line_s,
  output logic          drive_req,
  output logic          busy,
  output logic          rst_busy,
  output logic          presence,
  output logic          done_byte,
  output logic [DW-1:0] rx_byte,
  output logic          short_evt
);
  localparam int CW = $clog2(T_RST_TOTAL + 1);
  localparam int BW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] C_RLOW  = CW'(T_RST_LOW);
  localparam logic [CW-1:0] C_PRES  = CW'(T_RST_LOW + T_PRES);
  localparam logic [CW-1:0] C_REND  = CW'(T_RST_TOTAL - 1);
  localparam logic [CW-1:0] C_SEND  = CW'(T_SLOT - 1);
  localparam logic [CW-1:0] C_LOW1  = CW'(T_LOW1);
  localparam logic [CW-1:0] C_LOW0  = CW'(T_LOW0);
  localparam logic [CW-1:0] C_SAMP  = CW'(T_SAMPLE);
  localparam logic [BW-1:0] B_LAST  = BW'(DW - 1);

  eng_state_t    state;
  logic [CW-1:0] us_cnt;
  logic [DW-1:0] shreg;
  logic [BW-1:0] bitn;
  logic          samp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      us_cnt    <= '0;
      shreg     <= '0;
      bitn      <= '0;
      samp      <= 1'b1;
      presence  <= 1'b0;
      done_byte <= 1'b0;
      short_evt <= 1'b0;
    end else begin
      done_byte <= 1'b0;
      short_evt <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (rst_go) begin
            state    <= ENG_RST;
            us_cnt   <= '0;
            presence <= 1'b0;
          end else if (byte_go) begin
            state  <= ENG_SLOT;
            us_cnt <= '0;
            shreg  <= tx_byte;
            bitn   <= '0;
          end
        end
        ENG_RST: begin
          if (tick) begin
            us_cnt <= us_cnt + 1'b1;
            if (us_cnt == C_PRES) presence <= ~line_s;
            if (us_cnt == C_REND) begin
              state <= ENG_IDLE;
              if (!line_s) short_evt <= 1'b1;
            end
          end
        end
        ENG_SLOT: begin
          if (tick) begin
            us_cnt <= us_cnt + 1'b1;
            if (us_cnt == C_SAMP) samp <= line_s;
            if (us_cnt == C_SEND) begin
              us_cnt <= '0;
              if (!line_s) begin
                short_evt <= 1'b1;
                state     <= ENG_IDLE;
              end else begin
                shreg <= {samp, shreg[DW-1:1]};
                bitn  <= bitn + 1'b1;
                if (bitn == B_LAST) begin
                  state     <= ENG_IDLE;
                  done_byte <= 1'b1;
                end
              end
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ENG_RST:  drive_req = (us_cnt < C_RLOW);
      ENG_SLOT: drive_req = (us_cnt < (shreg[0] ? C_LOW1 : C_LOW0));
      default:  drive_req = 1'b0;
    endcase
  end

  assign busy     = (state != ENG_IDLE);
  assign rst_busy = (state == ENG_RST);
  assign rx_byte  = shreg;
endmodule

// File: rtl/ow_regs.sv
module ow_regs
  import ow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              eng_busy,
  input  logic              rst_busy,
  input  logic              presence,
  input  logic              done_byte,
  input  logic [REG_DW-1:0] rx_byte,
  input  logic              short_evt,
  input  logic              low_evt,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq,
  output logic              rst_go,
  output logic              byte_go,
  output logic              bb_en,
  output logic              bb_out,
  output logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  ien
);
  logic [REG_DW-1:0] rx_hold;
  logic [NFLAG-1:0]  set_v;
  logic [NFLAG-1:0]  clr_v;
  logic              wr_ctrl, wr_data, wr_flags, wr_ien;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign wr_flags = reg_wr && (reg_addr == A_FLAGS);
  assign wr_ien   = reg_wr && (reg_addr == A_IEN);

  assign rst_go  = wr_ctrl && reg_wdata[0] && !eng_busy;
  assign byte_go = wr_data && !eng_busy;

  always_comb begin
    set_v          = '0;
    set_v[F_RXRDY] = done_byte;
    set_v[F_SHORT] = short_evt;
    set_v[F_LOW]   = low_evt;
    clr_v          = wr_flags ? reg_wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bb_en   <= 1'b0;
      bb_out  <= 1'b0;
      ien     <= '0;
      flags   <= '0;
      rx_hold <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        bb_en  <= reg_wdata[1];
        bb_out <= reg_wdata[2];
      end
      if (wr_ien) ien <= reg_wdata[NFLAG-1:0];
      if (done_byte) rx_hold <= rx_byte;
      flags <= set_v | (flags & ~clr_v);
      irq   <= |(flags & ien);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= {3'b000, eng_busy, presence, bb_out, bb_en, rst_busy};
        A_DATA:  reg_rdata <= rx_hold;
        A_FLAGS: reg_rdata <= {{(REG_DW-NFLAG){1'b0}}, flags};
        default: reg_rdata <= {{(REG_DW-NFLAG){1'b0}}, ien};
      endcase
    end
  end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import ow_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int SYNC_STAGES = 2,
  parameter int T_RST_LOW   = 480,
  parameter int T_PRES      = 70,
  parameter int T_RST_TOTAL = 960,
  parameter int T_SLOT      = 65,
  parameter int T_LOW1      = 6,
  parameter int T_LOW0      = 60,
  parameter int T_SAMPLE    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              ow_drive_low,
  input  logic              ow_in,
  output logic              irq
);
  localparam int QUIET = SYNC_STAGES + 1;
  localparam int QW    = $clog2(QUIET + 1);
  localparam logic [QW-1:0] Q_MAX = QW'(QUIET);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;
  logic [QW-1:0]          quiet_cnt;
  logic                   tick, drive_req, eng_busy, rst_busy, presence;
  logic                   done_byte, short_evt, low_evt;
  logic [REG_DW-1:0]      rx_byte;
  logic                   rst_go, byte_go, bb_en, bb_out;
  logic [NFLAG-1:0]       flags, ien;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= ow_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ow_in};
      end
    end
  endgenerate
  assign line_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ow_drive_low <= 1'b0;
      quiet_cnt    <= '0;
    end else begin
      ow_drive_low <= bb_en ? bb_out : drive_req;
      if (ow_drive_low)          quiet_cnt <= '0;
      else if (quiet_cnt != Q_MAX) quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assign low_evt = !eng_busy && !bb_en && !ow_drive_low && (quiet_cnt == Q_MAX) && !line_s;

  ow_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (rst_go || byte_go),
    .tick (tick)
  );

  ow_engine #(
    .DW          (REG_DW),
    .T_RST_LOW   (T_RST_LOW),
    .T_PRES      (T_PRES),
    .T_RST_TOTAL (T_RST_TOTAL),
    .T_SLOT      (T_SLOT),
    .T_LOW1      (T_LOW1),
    .T_LOW0      (T_LOW0),
    .T_SAMPLE    (T_SAMPLE)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rst_go    (rst_go),
    .byte_go   (byte_go),
    .tx_byte   (reg_wdata),
    .line_s    (line_s),
    .drive_req (drive_req),
    .busy      (eng_busy),
    .rst_busy  (rst_busy),
    .presence  (presence),
    .done_byte (done_byte),
    .rx_byte   (rx_byte),
    .short_evt (short_evt)
  );

  ow_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .eng_busy  (eng_busy),
    .rst_busy  (rst_busy),
    .presence  (presence),
    .done_byte (done_byte),
    .rx_byte   (rx_byte),
    .short_evt (short_evt),
    .low_evt   (low_evt),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .rst_go    (rst_go),
    .byte_go   (byte_go),
    .bb_en     (bb_en),
    .bb_out    (bb_out),
    .flags     (flags),
    .ien       (ien)
  );
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk
  import ow_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ow_drive_low,
  input logic             irq,
  input logic             eng_busy,
  input logic             bb_en,
  input logic             bb_out,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] ien,
  input logic             rst_go,
  input logic             byte_go,
  input logic             done_byte,
  input logic             short_evt,
  input logic             low_evt
);
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!eng_busy && !bb_en) |=> !ow_drive_low); // R12
  AST_BB_LEVEL: assert property (@(posedge clk) disable iff (rst)
    bb_en |=> (ow_drive_low == $past(bb_out))); // R9
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rst_go || byte_go) |-> !eng_busy); // R8
  AST_RXRDY_SET: assert property (@(posedge clk) disable iff (rst)
    done_byte |=> flags[F_RXRDY]); // R5
  AST_SHORT_ABORT: assert property (@(posedge clk) disable iff (rst)
    short_evt |-> (!eng_busy && !done_byte)); // R6
  AST_SHORT_FLAG: assert property (@(posedge clk) disable iff (rst)
    short_evt |=> flags[F_SHORT]); // R6
  AST_LOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    low_evt |=> flags[F_LOW]); // R7
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ien)) |=> irq); // R10
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ien)) |=> !irq); // R10
endmodule

bind onewire_master ow_master_chk u_chk (.*);

// File: tb/sim_onewire_master.sv
`timescale 1ns/1ps
module sim_onewire_master;
  localparam int K = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ow_drive_low;
  logic       ow_in;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;

  // slave model state
  bit   pres_en = 1'b1;
  bit   short_en = 1'b0;
  bit   prev_drv = 1'b0;
  bit   hold0 = 1'b0;
  bit   after_rst = 1'b0;
  int   t_fall = 1000000;
  int   t_rel = 1000000;
  int   lowlen = 0;
  int   last_rst_low = 0;
  int   rst_seen = 0;
  int   slot_min = 1000000;
  int   slot_max = 0;
  int   bidx = 0;
  logic [7:0] resp = 8'hFF;
  logic [7:0] got = 8'h00;
  logic slave_low, line_pin;

  always #5 clk = ~clk;

  assign slave_low = (hold0 && t_fall < 30*K) ||
                     (pres_en && after_rst && t_rel >= 20*K && t_rel < 120*K);
  assign line_pin  = !(ow_drive_low || slave_low);
  assign ow_in     = short_en ? 1'b0 : line_pin;

  onewire_master #(.CLK_PER_US(K)) u0 (
    .clk, .rst, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
    .ow_drive_low, .ow_in, .irq
  );

  always @(negedge clk) begin
    if (ow_drive_low && !prev_drv) begin
      t_fall = 0;
      hold0  = !resp[bidx % 8];
    end else begin
      t_fall++;
    end
    if (!ow_drive_low && prev_drv) begin
      if (lowlen >= 400*K) begin
        rst_seen++;
        last_rst_low = lowlen;
        bidx = 0;
        after_rst = 1'b1;
        t_rel = 0;
        hold0 = 1'b0;
      end else begin
        if (lowlen < slot_min) slot_min = lowlen;
        if (lowlen > slot_max) slot_max = lowlen;
        t_rel++;
      end
    end else begin
      t_rel++;
    end
    if (t_fall == 30*K) begin
      got[bidx % 8] = line_pin;
      bidx++;
    end
    lowlen = ow_drive_low ? lowlen + 1 : 0;
    prev_drv = ow_drive_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] c;
    cyc = 0;
    for (int i = 0; i < 20000; i++) begin
      reg_read(2'd0, c);
      cyc += 2;
      if (!c[4]) break;
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit near(input int a, input int b);
    return (a >= b - 2) && (a <= b + 2);
  endfunction

  task automatic t_reset_state();
    logic [7:0] d;
    chk(ow_drive_low == 1'b0, "R12 drive", ow_drive_low, 0);
    chk(irq == 1'b0, "R12 irq", irq, 0);
    reg_read(2'd0, d); chk(d == 8'h00, "R12 ctrl", d, 0);
    reg_read(2'd2, d); chk(d == 8'h00, "R12 flags", d, 0);
  endtask

  task automatic t_bus_reset(input bit pres);
    logic [7:0] d;
    int cyc;
    pres_en = pres;
    reg_write(2'd0, 8'h01);
    reg_read(2'd0, d);
    chk(d[0] && d[4], "R1 running", d, 8'h11);
    wait_idle(cyc);
    chk(near(last_rst_low, 480*K), "R1 low time", last_rst_low, 480*K);
    chk(cyc > 900*K && cyc < 970*K, "R1 duration", cyc, 960*K);
    reg_read(2'd0, d);
    chk(d[0] == 1'b0 && d[3] == pres, "R2 presence", d, {4'h0, pres, 3'b000});
  endtask

  task automatic t_write_byte();
    logic [7:0] d;
    int cyc;
    resp = 8'hFF; slot_min = 1000000; slot_max = 0;
    reg_write(2'd1, 8'hA5);
    wait_idle(cyc);
    chk(got == 8'hA5, "R3 lsb first", got, 8'hA5);
    chk(near(slot_min, 6*K), "R3 one pulse", slot_min, 6*K);
    chk(near(slot_max, 60*K), "R3 zero pulse", slot_max, 60*K);
    chk(cyc > 510*K && cyc < 530*K, "R3 slot time", cyc, 520*K);
    reg_read(2'd1, d); chk(d == 8'hA5, "R4 echo", d, 8'hA5);
    reg_read(2'd2, d); chk(d == 8'h01, "R5 rx ready", d, 1);
    chk(irq == 1'b0, "R10 masked", irq, 0);
  endtask

  task automatic t_read_byte();
    logic [7:0] d;
    int cyc;
    reg_write(2'd2, 8'h07);
    resp = 8'h3C;
    reg_write(2'd1, 8'hFF);
    wait_idle(cyc);
    reg_read(2'd1, d); chk(d == 8'h3C, "R4 read slot", d, 8'h3C);
    resp = 8'hFF;
  endtask

  task automatic t_irq_clear();
    logic [7:0] d;
    reg_write(2'd3, 8'h01);
    wait_clk(2);
    chk(irq == 1'b1, "R10 raised", irq, 1);
    reg_write(2'd2, 8'h01);
    wait_clk(2);
    chk(irq == 1'b0, "R10 dropped", irq, 0);
    reg_read(2'd2, d); chk(d == 8'h00, "R11 w1c rx", d, 0);
    reg_write(2'd3, 8'h00);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    int cyc, rs;
    rs = rst_seen;
    reg_write(2'd1, 8'h12);
    reg_write(2'd1, 8'h99);
    reg_write(2'd0, 8'h01);
    wait_idle(cyc);
    chk(got == 8'h12, "R8 byte kept", got, 8'h12);
    chk(rst_seen == rs, "R8 no reset", rst_seen, rs);
    reg_read(2'd1, d); chk(d == 8'h12, "R8 rx", d, 8'h12);
    reg_write(2'd2, 8'h07);
  endtask

  task automatic t_line_low();
    logic [7:0] d;
    short_en = 1'b1; wait_clk(10); short_en = 1'b0; wait_clk(5);
    reg_read(2'd2, d); chk(d == 8'h04, "R7 line low", d, 4);
    reg_write(2'd2, 8'h04);
    reg_read(2'd2, d); chk(d == 8'h00, "R11 w1c low", d, 0);
  endtask

  task automatic t_bitbang();
    logic [7:0] d;
    reg_write(2'd0, 8'h06);
    wait_clk(1);
    chk(ow_drive_low == 1'b1, "R9 drive low", ow_drive_low, 1);
    reg_read(2'd0, d); chk(d == 8'h06, "R9 ctrl", d, 6);
    reg_write(2'd0, 8'h02);
    wait_clk(8);
    chk(ow_drive_low == 1'b0, "R9 release", ow_drive_low, 0);
    reg_write(2'd0, 8'h00);
    wait_clk(8);
    reg_read(2'd2, d); chk(d == 8'h00, "R9 no self low", d, 0);
  endtask

  task automatic t_short();
    logic [7:0] d;
    int cyc;
    short_en = 1'b1;
    reg_write(2'd0, 8'h01);
    wait_idle(cyc);
    reg_read(2'd2, d); chk(d[1] == 1'b1, "R6 short reset", d, 2);
    reg_write(2'd2, 8'h07);
    reg_write(2'd1, 8'h00);
    wait_idle(cyc);
    chk(cyc > 60*K && cyc < 80*K, "R6 abort time", cyc, 65*K);
    reg_read(2'd2, d); chk(d[1:0] == 2'b10, "R6 no rx", d, 2);
    short_en = 1'b0; wait_clk(5);
    reg_write(2'd2, 8'h02);
    reg_read(2'd2, d); chk(d == 8'h04, "R11 only short cleared", d, 4);
    reg_write(2'd2, 8'h04);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset_state();
    t_bus_reset(1'b1);
    t_bus_reset(1'b0);
    pres_en = 1'b1;
    t_write_byte();
    t_read_byte();
    t_irq_clear();
    t_busy_ignore();
    t_line_low();
    t_bitbang();
    t_short();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule